// File: doc/BRIEF.md
# Shift Register and FIFO Datapath for a Programmable I/O Engine

This block is the data side of one programmable I/O state machine. It holds an input shift register that gathers bits and an output shift register that hands them out, and each has a counter of the bits moved since its last reload. An external sequencer decodes the program and presents one command per cycle on a small command port. The block serves four commands: shift-in, shift-out, push and pull. Pin values and the two scratch registers X and Y arrive as plain input ports. Shift-out results leave on a data port tagged with their destination code.

A host loads words into a transmit FIFO, and pull commands move them into the output register. Push commands move the input register into a receive FIFO, and the host drains it. The block returns a stall flag when a blocking push or pull cannot complete, so the sequencer can hold its program counter. It also returns an output-register-empty flag that the sequencer tests as a jump condition.

Top module: `sm_shift_datapath`

## Requirements
- R1: After reset, both shift registers and the input counter are zero, the output counter reads 32 (osrEmpty high), both FIFOs are empty, and stall and rxOverflow are low.
- R2: Op code 0 (shift-in) shifts n bits of a source into the input register, where n is cmdCount and a count field of 0 means 32. Source codes on cmdSel: 0 pinsIn, 1 xIn, 2 yIn, 3 zeros, 6 the input register itself, 7 the output register; codes 4 and 5 act as zeros. With cfgInRight=0, the register shifts left and the low n source bits enter at bit 0. With cfgInRight=1, it shifts right and the low n source bits enter at the top.
- R3: Op code 1 (shift-out) removes n bits from the output register in the same cycle. outValid pulses, outDest repeats cmdSel, and outData carries the removed bits right-aligned: the top n bits when cfgOutRight=0, the bottom n bits when cfgOutRight=1. Destination code 6 also shifts those bits into the input register as in R2.
- R4: Op code 2 (push) writes the whole input register into the receive FIFO, then clears the register and its counter.
- R5: A push with cmdBlock=1 while the receive FIFO is full raises stall in that cycle and changes no state.
- R6: A push with cmdBlock=0 while the receive FIFO is full drops the word, still clears the input register, and sets rxOverflow, which then stays set until reset.
- R7: Op code 3 (pull) loads the oldest transmit FIFO word into the output register and resets its counter to 0. Words come out in the order the host wrote them.
- R8: A pull with cmdBlock=1 while the transmit FIFO is empty raises stall and changes no state.
- R9: A pull with cmdBlock=0 while the transmit FIFO is empty loads xIn into the output register.
- R10: With cmdCond=1, a push does nothing (and never stalls) unless the input counter has reached cfgPushThr. Likewise a pull does nothing unless the output counter has reached cfgPullThr. A threshold field of 0 means 32.
- R11: osrEmpty is high exactly when the output counter is at least cfgPullThr. Both counters add n per shift and saturate at 32.
- R12: Each FIFO holds 4 words. txFull is high with 4 words held, and a host write while full is dropped. rxEmpty is high with none held, and a read when empty does nothing. rxRdData shows the oldest word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgInRight | input | 1 | Input register shifts right when 1 |
| cfgOutRight | input | 1 | Output register shifts right when 1 |
| cfgPushThr | input | 5 | Push threshold, 0 means 32 |
| cfgPullThr | input | 5 | Pull threshold, 0 means 32 |
| cmdValid | input | 1 | A command is presented this cycle |
| cmdOp | input | 2 | 0 shift-in, 1 shift-out, 2 push, 3 pull |
| cmdSel | input | 3 | Source or destination code |
| cmdCount | input | 5 | Bit count, 0 means 32 |
| cmdBlock | input | 1 | Blocking push or pull |
| cmdCond | input | 1 | Threshold-conditional push or pull |
| pinsIn | input | 32 | Mapped input pin values |
| xIn | input | 32 | Scratch register X |
| yIn | input | 32 | Scratch register Y |
| outValid | output | 1 | Shift-out result valid |
| outDest | output | 3 | Destination code of the shift-out |
| outData | output | 32 | Right-aligned shifted-out bits |
| stall | output | 1 | Command cannot complete this cycle |
| osrEmpty | output | 1 | Output counter at or past pull threshold |
| txWrEn | input | 1 | Host write to transmit FIFO |
| txWrData | input | 32 | Host write data |
| txFull | output | 1 | Transmit FIFO full |
| rxRdEn | input | 1 | Host read from receive FIFO |
| rxRdData | output | 32 | Oldest receive FIFO word |
| rxEmpty | output | 1 | Receive FIFO empty |
| rxOverflow | output | 1 | Sticky dropped-push flag |

## Verification
The bench builds the block at its default width of 32 bits and FIFO depth of 4. At that size every bit count from 1 to 32 can be swept in both shift directions, for shift-in and for shift-out. Each result is compared against shifts and masks computed in the bench. The 4-deep FIFOs fill in a handful of commands, so full and empty handling can be reached directly. That covers blocking stalls, the dropped push with its sticky flag, the pull from X, and host writes lost while full. Small thresholds make the conditional push and pull switch from skipping to acting within a few shifts.

// File: rtl/sd_pkg.sv
package sd_pkg;
  typedef enum logic [1:0] {
    OP_IN   = 2'd0,
    OP_OUT  = 2'd1,
    OP_PUSH = 2'd2,
    OP_PULL = 2'd3
  } sdOpE;

  localparam logic [2:0] SEL_PINS = 3'd0;
  localparam logic [2:0] SEL_X    = 3'd1;
  localparam logic [2:0] SEL_Y    = 3'd2;
  localparam logic [2:0] SEL_ISR  = 3'd6;
  localparam logic [2:0] SEL_OSR  = 3'd7;

  typedef struct packed {
    logic isrShift;
    logic isrFromOut;
    logic isrClear;
    logic osrShift;
    logic osrLoadTx;
    logic osrLoadX;
    logic rxWrite;
    logic txPop;
    logic ovfSet;
    logic outFire;
  } sdStrobeT;
endpackage

// File: rtl/sd_fifo.sv
module sd_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic [W-1:0] wrData,
  input  logic         rdEn,
  output logic [W-1:0] rdData,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [LW-1:0] level;
  logic          doWr, doRd;

  assign full   = (level == LW'(DEPTH));
  assign empty  = (level == '0);
  assign doWr   = wrEn && !full;
  assign doRd   = rdEn && !empty;
  assign rdData = mem[rdPtr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (doWr) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (doWr) wrPtr <= bump(wrPtr);
      if (doRd) rdPtr <= bump(rdPtr);
      case ({doWr, doRd})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/sd_ctrl.sv
module sd_ctrl #(
  parameter int CW = 6
) (
  input  logic           cmdValid,
  input  logic [1:0]     cmdOp,
  input  logic [2:0]     cmdSel,
  input  logic           cmdBlock,
  input  logic           cmdCond,
  input  logic [CW-1:0]  isrCnt,
  input  logic [CW-1:0]  osrCnt,
  input  logic [CW-1:0]  pushThr,
  input  logic [CW-1:0]  pullThr,
  input  logic           rxFull,
  input  logic           txEmpty,
  output sd_pkg::sdStrobeT strb,
  output logic           stall
);
  import sd_pkg::*;

  logic pushSkip, pullSkip;
  assign pushSkip = cmdCond && (isrCnt < pushThr);
  assign pullSkip = cmdCond && (osrCnt < pullThr);

  always_comb begin
    strb  = '0;
    stall = 1'b0;
    if (cmdValid) begin
      case (sdOpE'(cmdOp))
        OP_IN: strb.isrShift = 1'b1;
        OP_OUT: begin
          strb.osrShift = 1'b1;
          strb.outFire  = 1'b1;
          if (cmdSel == SEL_ISR) begin
            strb.isrShift   = 1'b1;
            strb.isrFromOut = 1'b1;
          end
        end
        OP_PUSH: if (!pushSkip) begin
          if (!rxFull) begin
            strb.rxWrite  = 1'b1;
            strb.isrClear = 1'b1;
          end else if (cmdBlock) begin
            stall = 1'b1;
          end else begin
            strb.ovfSet   = 1'b1;
            strb.isrClear = 1'b1;
          end
        end
        default: if (!pullSkip) begin
          if (!txEmpty) begin
            strb.txPop     = 1'b1;
            strb.osrLoadTx = 1'b1;
          end else if (cmdBlock) begin
            stall = 1'b1;
          end else begin
            strb.osrLoadX = 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/sd_datapath.sv
module sd_datapath #(
  parameter int W  = 32,
  parameter int CW = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  sd_pkg::sdStrobeT strb,
  input  logic [2:0]       cmdSel,
  input  logic [CW-1:0]    shiftN,
  input  logic             cfgInRight,
  input  logic             cfgOutRight,
  input  logic [W-1:0]     pinsIn,
  input  logic [W-1:0]     xIn,
  input  logic [W-1:0]     yIn,
  input  logic [W-1:0]     txHead,
  output logic [W-1:0]     isr,
  output logic [CW-1:0]    isrCnt,
  output logic [CW-1:0]    osrCnt,
  output logic [W-1:0]     outData
);
  import sd_pkg::*;
  localparam int W2 = 2 * W;

  logic [W-1:0]  osr, osrNext, isrNext, inData, shData, alignLeft;
  logic [W2-1:0] outWide, inWide;
  logic [CW:0]   isrSum, osrSum;

  always_comb begin
    if (cfgOutRight) begin
      outWide = {osr, {W{1'b0}}} >> shiftN;
      osrNext = outWide[W2-1:W];
      outData = outWide[W-1:0] >> (W - int'(shiftN));
    end else begin
      outWide = {{W{1'b0}}, osr} << shiftN;
      outData = outWide[W2-1:W];
      osrNext = outWide[W-1:0];
    end
  end

  always_comb begin
    case (cmdSel)
      SEL_PINS: inData = pinsIn;
      SEL_X:    inData = xIn;
      SEL_Y:    inData = yIn;
      SEL_ISR:  inData = isr;
      SEL_OSR:  inData = osr;
      default:  inData = '0;
    endcase
    shData    = strb.isrFromOut ? outData : inData;
    alignLeft = shData << (W - int'(shiftN));
    if (cfgInRight) begin
      inWide  = {shData, isr} >> shiftN;
      isrNext = inWide[W-1:0];
    end else begin
      inWide  = {isr, alignLeft} << shiftN;
      isrNext = inWide[W2-1:W];
    end
  end

  assign isrSum = {1'b0, isrCnt} + {1'b0, shiftN};
  assign osrSum = {1'b0, osrCnt} + {1'b0, shiftN};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isr    <= '0;
      isrCnt <= '0;
      osr    <= '0;
      osrCnt <= CW'(W);
    end else begin
      if (strb.isrClear) begin
        isr    <= '0;
        isrCnt <= '0;
      end else if (strb.isrShift) begin
        isr    <= isrNext;
        isrCnt <= (isrSum > (CW+1)'(W)) ? CW'(W) : isrSum[CW-1:0];
      end
      if (strb.osrLoadTx || strb.osrLoadX) begin
        osr    <= strb.osrLoadTx ? txHead : xIn;
        osrCnt <= '0;
      end else if (strb.osrShift) begin
        osr    <= osrNext;
        osrCnt <= (osrSum > (CW+1)'(W)) ? CW'(W) : osrSum[CW-1:0];
      end
    end
  end
endmodule

// File: rtl/sm_shift_datapath.sv
module sm_shift_datapath #(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  localparam int CF   = $clog2(W),
  localparam int CW   = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgInRight,
  input  logic          cfgOutRight,
  input  logic [CF-1:0] cfgPushThr,
  input  logic [CF-1:0] cfgPullThr,
  input  logic          cmdValid,
  input  logic [1:0]    cmdOp,
  input  logic [2:0]    cmdSel,
  input  logic [CF-1:0] cmdCount,
  input  logic          cmdBlock,
  input  logic          cmdCond,
  input  logic [W-1:0]  pinsIn,
  input  logic [W-1:0]  xIn,
  input  logic [W-1:0]  yIn,
  output logic          outValid,
  output logic [2:0]    outDest,
  output logic [W-1:0]  outData,
  output logic          stall,
  output logic          osrEmpty,
  input  logic          txWrEn,
  input  logic [W-1:0]  txWrData,
  output logic          txFull,
  input  logic          rxRdEn,
  output logic [W-1:0]  rxRdData,
  output logic          rxEmpty,
  output logic          rxOverflow
);
  sd_pkg::sdStrobeT strb;
  logic [CW-1:0] shiftN, pushThr, pullThr, isrCnt, osrCnt;
  logic [W-1:0]  isr, txHead;
  logic          rxFull, txEmpty;

  assign shiftN  = (cmdCount == '0)   ? CW'(W) : CW'(cmdCount);
  assign pushThr = (cfgPushThr == '0) ? CW'(W) : CW'(cfgPushThr);
  assign pullThr = (cfgPullThr == '0) ? CW'(W) : CW'(cfgPullThr);

  sd_ctrl #(.CW(CW)) u_ctrl (
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdSel(cmdSel),
    .cmdBlock(cmdBlock), .cmdCond(cmdCond),
    .isrCnt(isrCnt), .osrCnt(osrCnt), .pushThr(pushThr), .pullThr(pullThr),
    .rxFull(rxFull), .txEmpty(txEmpty), .strb(strb), .stall(stall)
  );

  sd_datapath #(.W(W), .CW(CW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdSel(cmdSel), .shiftN(shiftN),
    .cfgInRight(cfgInRight), .cfgOutRight(cfgOutRight),
    .pinsIn(pinsIn), .xIn(xIn), .yIn(yIn), .txHead(txHead),
    .isr(isr), .isrCnt(isrCnt), .osrCnt(osrCnt), .outData(outData)
  );

  sd_fifo #(.W(W), .DEPTH(DEPTH)) u_txFifo (
    .clk(clk), .rstN(rstN), .wrEn(txWrEn), .wrData(txWrData),
    .rdEn(strb.txPop), .rdData(txHead), .full(txFull), .empty(txEmpty)
  );

  sd_fifo #(.W(W), .DEPTH(DEPTH)) u_rxFifo (
    .clk(clk), .rstN(rstN), .wrEn(strb.rxWrite), .wrData(isr),
    .rdEn(rxRdEn), .rdData(rxRdData), .full(rxFull), .empty(rxEmpty)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rxOverflow <= 1'b0;
    else if (strb.ovfSet) rxOverflow <= 1'b1;
  end

  assign outValid = strb.outFire;
  assign outDest  = cmdSel;
  assign osrEmpty = (osrCnt >= pullThr);
endmodule

// File: rtl/sd_checker.sv
module sd_checker #(
  parameter int W  = 32,
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rstN,
  input logic          cmdValid,
  input logic [1:0]    cmdOp,
  input logic          cmdCond,
  input logic          stall,
  input logic          rxRdEn,
  input logic          rxFull,
  input logic          rxEmpty,
  input logic          rxOverflow,
  input logic [CW-1:0] isrCnt,
  input logic [CW-1:0] osrCnt
);
  a_r5_stall_keeps_rx_full: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 2'd2 && stall && !rxRdEn) |=> rxFull);

  a_r8_stall_keeps_osr: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 2'd3 && stall) |=> $stable(osrCnt));

  a_r6_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    rxOverflow |=> rxOverflow);

  a_r4_push_clears_count: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 2'd2 && !cmdCond && !stall) |=> isrCnt == '0);

  a_r7_pull_clears_count: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 2'd3 && !cmdCond && !stall) |=> osrCnt == '0);

  a_r11_counts_saturate: assert property (@(posedge clk) disable iff (!rstN)
    (isrCnt <= CW'(W)) && (osrCnt <= CW'(W)));

  a_r12_rx_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(rxFull && rxEmpty));

  a_r5_stall_needs_cmd: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> (cmdValid && cmdOp[1]));
endmodule

bind sm_shift_datapath sd_checker #(.W(W), .CW(CW)) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
  .cmdCond(cmdCond), .stall(stall), .rxRdEn(rxRdEn), .rxFull(rxFull),
  .rxEmpty(rxEmpty), .rxOverflow(rxOverflow), .isrCnt(isrCnt), .osrCnt(osrCnt)
);

// File: tb/sm_shift_datapath_tb.sv
module sm_shift_datapath_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgInRight = 1'b0, cfgOutRight = 1'b0;
  logic [4:0] cfgPushThr = '0, cfgPullThr = '0;
  logic cmdValid = 1'b0;
  logic [1:0] cmdOp = '0;
  logic [2:0] cmdSel = '0;
  logic [4:0] cmdCount = '0;
  logic cmdBlock = 1'b0, cmdCond = 1'b0;
  logic [31:0] pinsIn = '0, xIn = '0, yIn = '0;
  logic outValid, stall, osrEmpty, txFull, rxEmpty, rxOverflow;
  logic [2:0] outDest;
  logic [31:0] outData, rxRdData;
  logic txWrEn = 1'b0, rxRdEn = 1'b0;
  logic [31:0] txWrData = '0;

  int checks = 0;
  int errors = 0;
  logic sStall, sValid;
  logic [2:0] sDest;
  logic [31:0] sOut, rd;

  always #4 clk = ~clk;

  sm_shift_datapath u_dut (
    .clk(clk), .rstN(rstN), .cfgInRight(cfgInRight), .cfgOutRight(cfgOutRight),
    .cfgPushThr(cfgPushThr), .cfgPullThr(cfgPullThr), .cmdValid(cmdValid),
    .cmdOp(cmdOp), .cmdSel(cmdSel), .cmdCount(cmdCount), .cmdBlock(cmdBlock),
    .cmdCond(cmdCond), .pinsIn(pinsIn), .xIn(xIn), .yIn(yIn),
    .outValid(outValid), .outDest(outDest), .outData(outData), .stall(stall),
    .osrEmpty(osrEmpty), .txWrEn(txWrEn), .txWrData(txWrData), .txFull(txFull),
    .rxRdEn(rxRdEn), .rxRdData(rxRdData), .rxEmpty(rxEmpty), .rxOverflow(rxOverflow)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [1:0] op, input logic [2:0] sel, input logic [4:0] cnt,
                     input logic blk = 1'b1, input logic cond = 1'b0);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdSel = sel; cmdCount = cnt;
    cmdBlock = blk; cmdCond = cond;
    #2;
    sStall = stall; sValid = outValid; sDest = outDest; sOut = outData;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic hostWrite(input logic [31:0] d);
    @(negedge clk);
    txWrEn = 1'b1; txWrData = d;
    @(negedge clk);
    txWrEn = 1'b0;
  endtask

  task automatic hostRead(output logic [31:0] d);
    @(negedge clk);
    #1 d = rxRdData;
    rxRdEn = 1'b1;
    @(negedge clk);
    rxRdEn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] mask, exp;
    logic [31:0] w;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 osrEmpty", 32'(osrEmpty), 32'd1);
    chk("R1 rxEmpty", 32'(rxEmpty), 32'd1);
    chk("R1 txFull", 32'(txFull), 32'd0);
    chk("R1 rxOverflow", 32'(rxOverflow), 32'd0);
    chk("R1 stall", 32'(stall), 32'd0);

    // R2 / R4 sweep: Y preload, then n bits of X, both directions
    for (int dir = 0; dir < 2; dir++) begin
      cfgInRight = dir[0];
      for (int n = 1; n <= 32; n++) begin
        xIn = 32'hA5C3_1E69 ^ (32'(n) * 32'h0101_0101);
        yIn = 32'h1234_5678 + 32'(n);
        mask = (64'h1 << n) - 1;
        if (dir == 0) exp = ({32'h0, yIn} << n) | ({32'h0, xIn} & mask);
        else exp = ({32'h0, yIn} >> n) | ({32'h0, xIn} << (32 - n));
        cmd(2'd0, 3'd2, 5'd0);
        cmd(2'd0, 3'd1, 5'(n));
        cmd(2'd2, 3'd0, 5'd0);
        hostRead(rd);
        chk(dir == 0 ? "R2 shift-in left" : "R2 shift-in right", rd, exp[31:0]);
      end
    end
    cfgInRight = 1'b0;

    // R2 other sources
    pinsIn = 32'hDEAD_BEEF;
    cmd(2'd0, 3'd0, 5'd0); cmd(2'd2, 3'd0, 5'd0); hostRead(rd);
    chk("R2 pins source", rd, 32'hDEAD_BEEF);
    yIn = 32'h89AB_CDEF;
    cmd(2'd0, 3'd2, 5'd0); cmd(2'd0, 3'd3, 5'd16); cmd(2'd2, 3'd0, 5'd0); hostRead(rd);
    chk("R2 zero source", rd, 32'hCDEF_0000);
    cmd(2'd0, 3'd2, 5'd0); cmd(2'd0, 3'd6, 5'd8); cmd(2'd2, 3'd0, 5'd0); hostRead(rd);
    chk("R2 self source", rd, 32'hABCD_EFEF);
    cmd(2'd0, 3'd2, 5'd0); cmd(2'd0, 3'd4, 5'd8); cmd(2'd2, 3'd0, 5'd0); hostRead(rd);
    chk("R2 reserved code as zeros", rd, 32'hABCD_EF00);

    // R3 / R7 / R11 sweep: pull then shift out n bits
    for (int dir = 0; dir < 2; dir++) begin
      cfgOutRight = dir[0];
      for (int n = 1; n <= 32; n++) begin
        w = 32'hC0FF_EE00 ^ (32'(n) * 32'h0102_0304);
        mask = (64'h1 << n) - 1;
        hostWrite(w);
        cmd(2'd3, 3'd0, 5'd0);
        chk("R11 osrEmpty low after pull", 32'(osrEmpty), 32'd0);
        cmd(2'd1, 3'd0, 5'(n));
        if (dir == 0) exp = {32'h0, w} >> (32 - n);
        else exp = {32'h0, w} & mask;
        chk(dir == 0 ? "R3 shift-out left" : "R3 shift-out right", sOut, exp[31:0]);
        chk("R11 osrEmpty vs count", 32'(osrEmpty), (n == 32) ? 32'd1 : 32'd0);
      end
    end
    chk("R3 outValid", 32'(sValid), 32'd1);
    chk("R3 outDest", 32'(sDest), 32'd0);
    cfgOutRight = 1'b0;

    // R2 OSR source and R3 ISR destination
    hostWrite(32'h1357_9BDF);
    cmd(2'd3, 3'd0, 5'd0);
    cmd(2'd0, 3'd7, 5'd0); cmd(2'd2, 3'd0, 5'd0); hostRead(rd);
    chk("R2 output register source", rd, 32'h1357_9BDF);
    cmd(2'd1, 3'd6, 5'd8);
    chk("R3 outDest isr", 32'(sDest), 32'd6);
    cmd(2'd2, 3'd0, 5'd0); hostRead(rd);
    chk("R3 shift-out into isr", rd, 32'h0000_0013);

    // R8 blocking pull on empty, R9 non-blocking pull loads X
    cmd(2'd1, 3'd0, 5'd0);
    cmd(2'd3, 3'd0, 5'd0, 1'b1);
    chk("R8 pull stall", 32'(sStall), 32'd1);
    chk("R8 osr untouched", 32'(osrEmpty), 32'd1);
    xIn = 32'h0BAD_F00D;
    cmd(2'd3, 3'd0, 5'd0, 1'b0);
    chk("R9 no stall", 32'(sStall), 32'd0);
    cmd(2'd1, 3'd0, 5'd0);
    chk("R9 loaded from X", sOut, 32'h0BAD_F00D);

    // R5 / R6 / R12 receive FIFO full handling
    for (int i = 1; i <= 4; i++) begin
      xIn = 32'(i);
      cmd(2'd0, 3'd1, 5'd0); cmd(2'd2, 3'd0, 5'd0);
    end
    xIn = 32'd99;
    cmd(2'd0, 3'd1, 5'd0);
    cmd(2'd2, 3'd0, 5'd0, 1'b1);
    chk("R5 push stall on full", 32'(sStall), 32'd1);
    chk("R5 no overflow on stall", 32'(rxOverflow), 32'd0);
    cmd(2'd2, 3'd0, 5'd0, 1'b0);
    chk("R6 drop no stall", 32'(sStall), 32'd0);
    chk("R6 overflow set", 32'(rxOverflow), 32'd1);
    for (int i = 1; i <= 4; i++) begin
      hostRead(rd);
      chk("R12 receive order", rd, 32'(i));
    end
    chk("R12 rxEmpty after drain", 32'(rxEmpty), 32'd1);
    cmd(2'd2, 3'd0, 5'd0); hostRead(rd);
    chk("R6 isr cleared by drop", rd, 32'd0);
    chk("R6 overflow sticky", 32'(rxOverflow), 32'd1);

    // R10 conditional push
    cfgPushThr = 5'd8;
    xIn = 32'd5;
    cmd(2'd0, 3'd1, 5'd4);
    cmd(2'd2, 3'd0, 5'd0, 1'b1, 1'b1);
    chk("R10 cond push skipped no stall", 32'(sStall), 32'd0);
    chk("R10 cond push skipped", 32'(rxEmpty), 32'd1);
    xIn = 32'd3;
    cmd(2'd0, 3'd1, 5'd4);
    cmd(2'd2, 3'd0, 5'd0, 1'b1, 1'b1);
    hostRead(rd);
    chk("R10 cond push at threshold", rd, 32'h53);
    cfgPushThr = 5'd0;

    // R10 / R11 conditional pull
    cfgPullThr = 5'd16;
    hostWrite(32'hAABB_CCDD);
    hostWrite(32'h1122_3344);
    cmd(2'd3, 3'd0, 5'd0);
    cmd(2'd1, 3'd0, 5'd8);
    chk("R3 first byte", sOut, 32'hAA);
    chk("R11 below pull threshold", 32'(osrEmpty), 32'd0);
    cmd(2'd3, 3'd0, 5'd0, 1'b1, 1'b1);
    cmd(2'd1, 3'd0, 5'd8);
    chk("R10 cond pull skipped", sOut, 32'hBB);
    chk("R11 at pull threshold", 32'(osrEmpty), 32'd1);
    cmd(2'd3, 3'd0, 5'd0, 1'b1, 1'b1);
    cmd(2'd1, 3'd0, 5'd0);
    chk("R10 cond pull taken", sOut, 32'h1122_3344);
    cfgPullThr = 5'd0;

    // R12 transmit FIFO full and order
    for (int i = 0; i < 4; i++) hostWrite(32'h100 + 32'(i));
    chk("R12 txFull", 32'(txFull), 32'd1);
    hostWrite(32'hFFFF_FFFF);
    for (int i = 0; i < 4; i++) begin
      cmd(2'd3, 3'd0, 5'd0);
      cmd(2'd1, 3'd0, 5'd0);
      chk("R7 transmit order", sOut, 32'h100 + 32'(i));
    end
    cmd(2'd3, 3'd0, 5'd0, 1'b1);
    chk("R12 write while full dropped", 32'(sStall), 32'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule